// File: doc/BRIEF.md
# GPIO Port Register File with Windowed Access

This block holds the direction, pullup and output-latch state for a bank of general-purpose ports numbered 4 to 31. A host reaches it over a simple byte bus with a 7-bit register address, a write strobe and a read strobe. From this state it drives one output-enable, one output-value and one pullup-enable line for each port, and it samples the level of each port pin for reads.

Each port has a 2-bit mode field. The fields are packed four to a byte in a small block of mode registers. The output latch of a port can be reached in two ways: alone through its own single-port address, or as one lane of an 8-port window. The window can start at any port number from 0 to 63. Lanes of a window that land on ports that do not exist are dropped on a write and read as zero. A control register selects between normal operation and shutdown. In shutdown every driver and pullup is released, while all stored settings are kept.

Top module: `gpio_port_regfile`

## Requirements
- R1: After reset, every mode register reads 0xAA (every port is an input without pullup), every output latch is 0, the control register reads 0x00 (shutdown), and port_oe, port_out and port_pu are all zero.
- R2: The mode of port p sits in the byte at address 0x08 + p/4, in bits [2*(p%4)+1 : 2*(p%4)]. Code 01 makes the port drive its latch (port_oe=1, port_out=latch). Code 10 makes it an input without pullup. Code 11 makes it an input with port_pu=1. port_out is 0 whenever port_oe is 0, and port_oe and port_pu are never both set.
- R3: Mode code 00 is stored and reads back as written, and the port then behaves as an input without pullup.
- R4: Address 0x20 + p (p = 4..31) reaches port p through bit 0. A write stores wdata[0] in the latch. A read returns the latch when the port is driving, and the pin level otherwise. Bits 7:1 read as 0.
- R5: Addresses 0x20 to 0x23 (ports 0 to 3) read as 0x00, and a write to them changes nothing.
- R6: Address 0x40 + k (k = 0..63) is a window in which data bit j belongs to port k+j. A write stores each bit into the latch of its port, and a read returns each port's value as in R4.
- R7: In a window, lanes whose port number is below 4 or above 31 are ignored on a write and read as 0.
- R8: Control register 0x04: bit 0 = 1 selects normal operation and bit 0 = 0 selects shutdown. A read returns the stored bit in bit 0, with bits 7:1 zero.
- R9: In shutdown, port_oe, port_pu and port_out are all 0 and every port reads as an input. Mode and latch registers stay writable and keep their contents, and they take effect again when normal operation resumes.
- R10: Any other address (0x00 to 0x03, 0x05 to 0x08, 0x10 to 0x1F) reads 0x00, and writes to it are ignored.
- R11: rdata is registered. It takes the addressed value at the clock edge on which rd_en is high, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 7 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rdata | output | 8 | Registered read data |
| port_in | input | NUM_PORTS | Sampled pin levels, bit i is port 4+i |
| port_oe | output | NUM_PORTS | Driver enable, bit i is port 4+i |
| port_out | output | NUM_PORTS | Driven value, bit i is port 4+i |
| port_pu | output | NUM_PORTS | Pullup enable, bit i is port 4+i |

## Verification
The pin pattern is irregular, so windows that start at different offsets give different read values. A window shifted by one lane, or a lane order that is reversed, is therefore seen as a wrong value. Reads of ports whose latch differs from the pin separate latch-return from pin-return, and this is tried for the output, input, reserved-code and shutdown cases. Windows that straddle port 4 and port 31, and the window at k=63, show that lanes which do not exist are dropped. Writes made during shutdown, followed by a return to normal operation, show that the stored state is kept rather than cleared.

// File: rtl/gpio_rf_pkg.sv
// Package: shared constants and types for the GPIO port register file.
// Assumes a 7-bit register address and 8-bit data.
package gpio_rf_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 7;

    localparam logic [ADDR_W-1:0] ADDR_CTRL    = 7'h04;
    localparam logic [ADDR_W-1:0] ADDR_MODE_LO = 7'h09;

    typedef enum logic [1:0] {
        MODE_RSVD     = 2'b00,
        MODE_PUSHPULL = 2'b01,
        MODE_IN       = 2'b10,
        MODE_IN_PU    = 2'b11
    } port_mode_e;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_CTRL,
        ACC_MODE,
        ACC_SINGLE,
        ACC_WINDOW
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e  kind;
        logic [5:0] sel;
    } acc_dec_t;

endpackage

// File: rtl/gpio_addr_decode.sv
// Module: gpio_addr_decode
// Sorts a register address into an access kind and a selector. For a mode
// access the selector is the byte index, for a single-port access it is the
// port number, and for a window access it is the first port of the window.
// Assumes the mode bytes sit at ADDR_MODE_LO onward and lie below 0x20.
module gpio_addr_decode
    import gpio_rf_pkg::*;
#(
    parameter int N_MODE_BYTES = 7
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_dec_t          dec
);

    localparam logic [ADDR_W-1:0] MODE_END = ADDR_W'(int'(ADDR_MODE_LO) + N_MODE_BYTES);

    // Classify the address into one access kind.
    always_comb begin
        dec.kind = ACC_NONE;
        dec.sel  = '0;
        if (addr == ADDR_CTRL) begin
            dec.kind = ACC_CTRL;
        end else if (addr >= ADDR_MODE_LO && addr < MODE_END) begin
            dec.kind = ACC_MODE;
            dec.sel  = 6'(addr - ADDR_MODE_LO);
        end else if (addr[6:5] == 2'b01) begin
            dec.kind = ACC_SINGLE;
            dec.sel  = {1'b0, addr[4:0]};
        end else if (addr[6]) begin
            dec.kind = ACC_WINDOW;
            dec.sel  = addr[5:0];
        end
    end

endmodule

// File: rtl/gpio_port_cell.sv
// Module: gpio_port_cell
// State for one port: its 2-bit mode and its output latch. Turns these,
// together with the run/shutdown state, into the driver controls, and gives
// the level a read returns for this port.
// Assumes the write enables come from a decoder that raises at most one.
module gpio_port_cell
    import gpio_rf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       mode_we,
    input  logic [1:0] mode_wd,
    input  logic       latch_we,
    input  logic       latch_wd,
    input  logic       pin,
    output logic [1:0] mode_q,
    output logic       oe,
    output logic       out,
    output logic       pu,
    output logic       level
);

    port_mode_e mode_r;
    logic       latch_r;

    // Mode field; resets to input without pullup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_r <= MODE_IN;
        end else if (mode_we) begin
            mode_r <= port_mode_e'(mode_wd);
        end
    end

    // Output latch; resets low and is kept through shutdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_r <= 1'b0;
        end else if (latch_we) begin
            latch_r <= latch_wd;
        end
    end

    // Driver controls; a reserved code acts as a plain input.
    always_comb begin
        mode_q = mode_r;
        oe     = run && (mode_r == MODE_PUSHPULL);
        pu     = run && (mode_r == MODE_IN_PU);
        out    = oe && latch_r;
        level  = oe ? latch_r : pin;
    end

endmodule

// File: rtl/gpio_port_regfile.sv
// Module: gpio_port_regfile (top)
// Register file for NUM_PORTS GPIO ports numbered FIRST_PORT upward. The
// host reaches it through a byte bus with mode bytes, a control register,
// single-port addresses and 8-lane windows that may start at any port.
// Assumes NUM_PORTS is a multiple of 4, the last port is at most 31, and
// port_in is already synchronous to clk.
module gpio_port_regfile
    import gpio_rf_pkg::*;
#(
    parameter int FIRST_PORT = 4,
    parameter int NUM_PORTS  = 28
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [6:0]           addr,
    input  logic [7:0]           wdata,
    input  logic                 wr_en,
    input  logic                 rd_en,
    output logic [7:0]           rdata,
    input  logic [NUM_PORTS-1:0] port_in,
    output logic [NUM_PORTS-1:0] port_oe,
    output logic [NUM_PORTS-1:0] port_out,
    output logic [NUM_PORTS-1:0] port_pu
);

    localparam int N_MODE_BYTES = NUM_PORTS / 4;
    localparam int WIN_SPAN     = 64;
    localparam int PAD_W        = WIN_SPAN + DATA_W;

    acc_dec_t                  dec;
    logic                      run_q;
    logic [2*NUM_PORTS-1:0]    mode_flat;
    logic [NUM_PORTS-1:0]      level;
    logic [PAD_W-1:0]          level_pad;
    logic [DATA_W-1:0]         rd_val;

    gpio_addr_decode #(
        .N_MODE_BYTES (N_MODE_BYTES)
    ) dec_i (
        .addr (addr),
        .dec  (dec)
    );

    // Run/shutdown bit; resets to shutdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (wr_en && dec.kind == ACC_CTRL) begin
            run_q <= wdata[0];
        end
    end

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        localparam int PNUM = FIRST_PORT + i;
        logic       mode_we;
        logic       latch_we;
        logic       latch_wd;
        logic [6:0] lane;
        logic [1:0] mode_q;

        assign mode_we = wr_en && dec.kind == ACC_MODE && dec.sel == 6'(i / 4);
        assign lane    = 7'(PNUM) - {1'b0, dec.sel};

        // Latch write select: single address or a window lane on this port.
        always_comb begin
            latch_we = 1'b0;
            latch_wd = 1'b0;
            if (wr_en && dec.kind == ACC_SINGLE && dec.sel == 6'(PNUM)) begin
                latch_we = 1'b1;
                latch_wd = wdata[0];
            end else if (wr_en && dec.kind == ACC_WINDOW && lane < 7'(DATA_W)) begin
                latch_we = 1'b1;
                latch_wd = wdata[lane[2:0]];
            end
        end

        gpio_port_cell cell_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run_q),
            .mode_we  (mode_we),
            .mode_wd  (wdata[2*(i%4) +: 2]),
            .latch_we (latch_we),
            .latch_wd (latch_wd),
            .pin      (port_in[i]),
            .mode_q   (mode_q),
            .oe       (port_oe[i]),
            .out      (port_out[i]),
            .pu       (port_pu[i]),
            .level    (level[i])
        );

        assign mode_flat[2*i +: 2] = mode_q;
    end

    // Read view indexed by port number; missing ports are zero.
    assign level_pad = PAD_W'({level, {FIRST_PORT{1'b0}}});

    // Read multiplexer over the access kinds.
    always_comb begin
        rd_val = '0;
        case (dec.kind)
            ACC_CTRL:   rd_val = {7'b0, run_q};
            ACC_MODE:   rd_val = mode_flat[int'(dec.sel)*DATA_W +: DATA_W];
            ACC_SINGLE: rd_val = {7'b0, level_pad[dec.sel]};
            ACC_WINDOW: rd_val = level_pad[dec.sel +: DATA_W];
            default:    rd_val = '0;
        endcase
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_val;
        end
    end

endmodule

// File: rtl/gpio_port_regfile_chk.sv
// Module: gpio_port_regfile_chk
// Port-level checker bound to gpio_port_regfile. It watches only the top
// ports. Assumes the reset is synchronous and active low.
module gpio_port_regfile_chk #(
    parameter int NUM_PORTS = 28
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [6:0]           addr,
    input logic [7:0]           wdata,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic [7:0]           rdata,
    input logic [NUM_PORTS-1:0] port_in,
    input logic [NUM_PORTS-1:0] port_oe,
    input logic [NUM_PORTS-1:0] port_out,
    input logic [NUM_PORTS-1:0] port_pu
);

    AST_OE_PU_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (port_oe & port_pu) == '0); // R2

    AST_OUT_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (port_out & ~port_oe) == '0); // R2

    AST_SINGLE_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && addr[6:5] == 2'b01 |=> rdata[7:1] == 7'b0); // R4

    AST_VIRTUAL_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr[6:2] == 5'b01000 |=>
            $stable(port_out) && $stable(port_oe) && $stable(port_pu)); // R5

    AST_WINDOW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && addr == 7'h7F |=> rdata == 8'h00); // R7

    AST_SHUTDOWN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == 7'h04 && !wdata[0] |=> port_oe == '0 && port_pu == '0); // R9

    AST_UNDECODED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && addr[6:4] == 3'b001 |=> rdata == 8'h00); // R10

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R11

endmodule

bind gpio_port_regfile gpio_port_regfile_chk #(
    .NUM_PORTS (NUM_PORTS)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wdata    (wdata),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rdata    (rdata),
    .port_in  (port_in),
    .port_oe  (port_oe),
    .port_out (port_out),
    .port_pu  (port_pu)
);

// File: tb/gpio_port_regfile_tb_top.sv
`timescale 1ns/1ps
// Bench for gpio_port_regfile: a vector table walked by one loop, then
// directed tests for outputs, shutdown, window edges and reset.
module gpio_port_regfile_tb_top;

    localparam int NP = 28;
    // Pin levels, bit i = port 4+i: high on ports 4,10,11,12,13,16,18,21,23,25,26,28,31.
    localparam logic [NP-1:0] PINS = 28'h96A53C1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [6:0]    addr = '0;
    logic [7:0]    wdata = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [7:0]    rdata;
    logic [NP-1:0] port_in = PINS;
    logic [NP-1:0] port_oe;
    logic [NP-1:0] port_out;
    logic [NP-1:0] port_pu;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;

    always #4 clk = ~clk;

    gpio_port_regfile dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wdata    (wdata),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .rdata    (rdata),
        .port_in  (port_in),
        .port_oe  (port_oe),
        .port_out (port_out),
        .port_pu  (port_pu)
    );

    // Vector: {is_read, addr, data, expected read value}
    localparam int NV = 26;
    localparam logic [23:0] VEC [NV] = '{
        {1'b1, 7'h09, 8'h00, 8'hAA},  // R1 reset mode byte
        {1'b1, 7'h0F, 8'h00, 8'hAA},  // R1 last mode byte
        {1'b1, 7'h04, 8'h00, 8'h00},  // R1 shutdown after reset
        {1'b1, 7'h2C, 8'h00, 8'h01},  // R4 port 12 input, pin high
        {1'b1, 7'h44, 8'h00, 8'hC1},  // R6 window at 4
        {1'b1, 7'h42, 8'h00, 8'h04},  // R7 window at 2, ports 2-3 absent
        {1'b1, 7'h5C, 8'h00, 8'h09},  // R7 window at 28, ports above 31 absent
        {1'b0, 7'h04, 8'h01, 8'h00},  // R8 enter normal operation
        {1'b1, 7'h04, 8'h00, 8'h01},  // R8 read back
        {1'b0, 7'h0B, 8'h55, 8'h00},  // R2 ports 12-15 outputs
        {1'b0, 7'h2D, 8'h01, 8'h00},  // R4 port 13 latch high
        {1'b1, 7'h0B, 8'h00, 8'h55},  // R2 mode read back
        {1'b1, 7'h2D, 8'h00, 8'h01},  // R4 output returns latch
        {1'b1, 7'h2C, 8'h00, 8'h00},  // R4 output latch 0 over pin 1
        {1'b0, 7'h4C, 8'hF0, 8'h00},  // R6 window write at 12
        {1'b1, 7'h4C, 8'h00, 8'h50},  // R6 latches 12-15, pins 16-19
        {1'b1, 7'h31, 8'h00, 8'h00},  // R4 input 17 returns pin, not latch
        {1'b0, 7'h0C, 8'h00, 8'h00},  // R3 reserved code on 16-19
        {1'b1, 7'h0C, 8'h00, 8'h00},  // R3 reserved stored
        {1'b1, 7'h31, 8'h00, 8'h00},  // R3 reserved acts as input
        {1'b0, 7'h10, 8'hFF, 8'h00},  // R10 undecoded write
        {1'b1, 7'h10, 8'h00, 8'h00},  // R10 undecoded read
        {1'b1, 7'h07, 8'h00, 8'h00},  // R10 undecoded read
        {1'b0, 7'h21, 8'h01, 8'h00},  // R5 virtual write
        {1'b1, 7'h21, 8'h00, 8'h00},  // R5 virtual read
        {1'b1, 7'h7F, 8'h00, 8'h00}   // R7 window at 63
    };
    localparam string VTAG [NV] = '{
        "R1","R1","R1","R4","R6","R7","R7","R8","R8","R2","R4","R2","R4",
        "R4","R6","R6","R4","R3","R3","R3","R10","R10","R10","R5","R5","R7"
    };

    // Compare and count one check.
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One write cycle.
    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One read cycle; value is taken after the capturing edge.
    task automatic rd(input logic [6:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs after reset
        chk("R1 oe", 32'(port_oe), 32'h0);
        chk("R1 out", 32'(port_out), 32'h0);
        chk("R1 pu", 32'(port_pu), 32'h0);

        for (int n = 0; n < NV; n++) begin
            if (VEC[n][23]) begin
                rd(VEC[n][22:16], v);
                chk(VTAG[n], 32'(v), 32'(VEC[n][7:0]));
            end else begin
                wr(VEC[n][22:16], VEC[n][15:8]);
            end
        end

        // R2/R3: ports 12-15 drive, reserved 16-19 do not
        chk("R2 oe", 32'(port_oe), 32'h0000F00);
        chk("R3 out", 32'(port_out), 32'h0);
        wr(7'h0E, 8'hFF);
        chk("R2 pu", 32'(port_pu), 32'h0F00000);
        // R6: window write drives latches of outputs 12-15
        wr(7'h4C, 8'h0F);
        chk("R6 out", 32'(port_out), 32'h0000F00);
        chk("R3 oe", 32'(port_oe), 32'h0000F00);

        // R9: shutdown releases everything, state kept and writable
        wr(7'h04, 8'h00);
        chk("R9 oe", 32'(port_oe), 32'h0);
        chk("R9 pu", 32'(port_pu), 32'h0);
        chk("R9 out", 32'(port_out), 32'h0);
        wr(7'h4C, 8'h05);
        rd(7'h0B, v);
        chk("R9 mode kept", 32'(v), 32'h55);
        rd(7'h2E, v);
        chk("R9 reads pin", 32'(v), 32'h0);
        wr(7'h04, 8'h01);
        chk("R9 oe back", 32'(port_oe), 32'h0000F00);
        chk("R9 out back", 32'(port_out), 32'h0000500);
        chk("R9 pu back", 32'(port_pu), 32'h0F00000);

        // R7: windows straddling the top and bottom of the port range
        wr(7'h0F, 8'h55);
        wr(7'h5C, 8'hFF);
        chk("R7 top window", 32'(port_out), 32'hF000500);
        wr(7'h09, 8'h55);
        wr(7'h40, 8'hFF);
        chk("R7 bottom window", 32'(port_out), 32'hF00050F);
        chk("R7 oe", 32'(port_oe), 32'hF000F0F);

        // R5: virtual single port write
        wr(7'h22, 8'h01);
        chk("R5 out", 32'(port_out), 32'hF00050F);

        // R10: write to undecoded address next to mode bytes
        wr(7'h08, 8'hFF);
        rd(7'h09, v);
        chk("R10 mode intact", 32'(v), 32'h55);
        chk("R10 out", 32'(port_out), 32'hF00050F);
        rd(7'h08, v);
        chk("R10 read", 32'(v), 32'h0);

        // R11: rdata holds between reads
        rd(7'h09, v);
        wr(7'h04, 8'h01);
        @(negedge clk);
        addr = 7'h0E;
        repeat (3) @(negedge clk);
        chk("R11 hold", 32'(rdata), 32'h55);

        // R1: reset in the middle of a run clears latches and modes
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 oe again", 32'(port_oe), 32'h0);
        chk("R1 rdata", 32'(rdata), 32'h0);
        rd(7'h0B, v);
        chk("R1 mode again", 32'(v), 32'hAA);
        wr(7'h04, 8'h01);
        wr(7'h0B, 8'h55);
        chk("R1 latch low", 32'(port_out), 32'h0);
        chk("R2 oe new", 32'(port_oe), 32'h0000F00);

        finish_run();
    end

endmodule